// File: doc/BRIEF.md
# Retransmit FIFO with Zone Flags

A first-in first-out buffer for 9-bit words with a power-of-two depth. It is modelled synchronously: the write, read and retransmit strobes are sampled on the rising clock edge. Words leave in the order they arrived. A retransmit strobe rewinds only the read side to the first storage location, so a block that has already been read can be replayed without writing it again.

Four active-low status flags are derived from the occupancy: full, empty, more-than-half-full, and a single zone flag. The zone flag is active in the lowest eighth and in the highest eighth of the occupancy range. The three-state output bus is represented by a data word and a drive indicator. Output enable gates only the drive indicator, so a read with output enable low still consumes a word. If a read is held active while the FIFO is empty, the first word that arrives is presented as soon as empty clears. That word is consumed when the read is released.

Top module: `retx_fifo`

## Requirements
- R1: After reset, full_no=1, half_no=1, empty_no=0, zone_no=0 and drive_o=0.
- R2: A read accepted on an edge loads the oldest stored word onto dout_o on that edge, with drive_o=1 while oe_i=1. Words come out in write order.
- R3: A write on an edge where full_no=0 stores nothing and does not move the write pointer.
- R4: A read on an edge where empty_no=0 leaves drive_o=0 and does not move the read pointer.
- R5: When rt_i=1 and wr_i=rd_i=0, the next read returns the first word written since reset. The write pointer is unchanged. The flags on the following cycle reflect the rewound occupancy.
- R6: When rt_i=1 in the same cycle as wr_i=1 or rd_i=1, the rewind does not take place and the write or read proceeds normally.
- R7: zone_no=0 when the occupancy is at most DEPTH/8 or at least DEPTH-DEPTH/8. Otherwise zone_no=1.
- R8: half_no=0 exactly when the occupancy is greater than DEPTH/2.
- R9: A read with oe_i=0 advances the read pointer and leaves drive_o=0.
- R10: If rd_i is held at 1 while the FIFO is empty, the first word written appears on dout_o with drive_o=1 one edge after empty_no rises. The read pointer stays put while rd_i remains at 1. The word is consumed on the edge where rd_i is seen at 0.
- R11: A write and a read on the same edge, with the FIFO neither full nor empty, leave the occupancy unchanged.
- R12: full_no=0 exactly at DEPTH words and empty_no=0 exactly at zero words. This holds across pointer wrap-around, where the addresses are equal in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | WIDTH | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rt_i | input | 1 | Retransmit strobe; rewinds the read pointer |
| oe_i | input | 1 | Output enable |
| dout_o | output | WIDTH | Read data |
| drive_o | output | 1 | Read data is being driven |
| full_no | output | 1 | Full, active low |
| empty_no | output | 1 | Empty, active low |
| half_no | output | 1 | More than half full, active low |
| zone_no | output | 1 | Within the lowest or highest eighth of occupancy, active low |

## Verification
The hardest state to reach is the held read across an empty FIFO. The read strobe has to stay high through the edge where the write lands, while empty is still active. Only then is the presented word consumed on the release edge rather than on the next assertion. The bench holds rd_i for several cycles on an empty FIFO and writes two words under it. It then checks that the first word stays on the output, and that the second word is next after one release and one further read. Pointer wrap is reached by filling and draining the whole depth twice, so that full is seen with the two address fields equal.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  typedef struct packed {
    logic full_n;
    logic empty_n;
    logic half_n;
    logic zone_n;
  } fifo_flags_t;
endpackage

// File: rtl/retx_fifo_mem.sv
module retx_fifo_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/retx_fifo_ptr.sv
module retx_fifo_ptr #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_go_i,
  input  logic        rd_go_i,
  input  logic        rt_go_i,
  output logic [AW:0] wptr_o,
  output logic [AW:0] rptr_o
);
  logic [AW:0] wptr_q, rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_go_i) wptr_q <= wptr_q + 1'b1;
      // rewind keeps the wrap bit aligned so occupancy equals the write address
      if (rt_go_i)      rptr_q <= {wptr_q[AW], {AW{1'b0}}};
      else if (rd_go_i) rptr_q <= rptr_q + 1'b1;
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;

  assert_rt_rewind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_go_i |=> (rptr_q[AW-1:0] == '0));
  assert_rt_wptr_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_go_i && !wr_go_i) |=> $stable(wptr_q));
endmodule

// File: rtl/retx_fifo_flags.sv
module retx_fifo_flags
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [AW:0] wptr_i,
  input  logic [AW:0] rptr_i,
  output logic [AW:0] occ_o,
  output fifo_flags_t flags_o
);
  localparam logic [AW:0] LoMark   = (AW+1)'(DEPTH / 8);
  localparam logic [AW:0] HiMark   = (AW+1)'(DEPTH - DEPTH / 8);
  localparam logic [AW:0] HalfMark = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] FullMark = (AW+1)'(DEPTH);

  logic [AW:0] occ;

  assign occ = wptr_i - rptr_i;

  always_comb begin
    flags_o.full_n  = (occ != FullMark);
    flags_o.empty_n = (occ != '0);
    flags_o.half_n  = !(occ > HalfMark);
    flags_o.zone_n  = !((occ <= LoMark) || (occ >= HiMark));
  end

  assign occ_o = occ;

  assert_full_empty_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flags_o.full_n && !flags_o.empty_n));
  assert_occ_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= FullMark);
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             rt_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             drive_o,
  output logic             full_no,
  output logic             empty_no,
  output logic             half_no,
  output logic             zone_no
);
  logic [AW:0]      wptr, rptr, occ;
  logic [WIDTH-1:0] rdata;
  fifo_flags_t      flags;
  logic             wr_go, rd_go, rt_go, empty;
  logic             armed_q, ft_hold_q;
  logic [WIDTH-1:0] dout_q;
  logic             drive_q;

  assign empty = !flags.empty_n;
  assign wr_go = wr_i && flags.full_n;
  // armed read consumes on the edge; a flow-through word is consumed on release
  assign rd_go = (rd_i && armed_q && !empty) || (!rd_i && ft_hold_q);
  assign rt_go = rt_i && !wr_i && !rd_i;

  retx_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_go_i (wr_go),
    .rd_go_i (rd_go),
    .rt_go_i (rt_go),
    .wptr_o  (wptr),
    .rptr_o  (rptr)
  );

  retx_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_go),
    .waddr_i (wptr[AW-1:0]),
    .wdata_i (din_i),
    .raddr_i (rptr[AW-1:0]),
    .rdata_o (rdata)
  );

  retx_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wptr_i  (wptr),
    .rptr_i  (rptr),
    .occ_o   (occ),
    .flags_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b1;
      ft_hold_q <= 1'b0;
      dout_q    <= '0;
      drive_q   <= 1'b0;
    end else begin
      if (!rd_i)      armed_q <= 1'b1;
      else if (empty) armed_q <= 1'b0;

      if (!rd_i)                      ft_hold_q <= 1'b0;
      else if (!armed_q && !empty)    ft_hold_q <= 1'b1;

      if (rd_i && !empty) begin
        dout_q  <= rdata;
        drive_q <= oe_i;
      end else begin
        drive_q <= 1'b0;
      end
    end
  end

  assign dout_o   = dout_q;
  assign drive_o  = drive_q;
  assign full_no  = flags.full_n;
  assign empty_no = flags.empty_n;
  assign half_no  = flags.half_n;
  assign zone_no  = flags.zone_n;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_no) |=> $stable(wptr));
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_no) |=> ($stable(rptr) && !drive_o));
  assert_oe_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> !drive_o);
  assert_simul_occ_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && rd_go && !rt_go) |=> (occ == $past(occ)));
  assert_flow_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ft_hold_q) |=> $stable(rptr));
endmodule

// File: tb/sim_retx_fifo.sv
module sim_retx_fifo;
  localparam int W = 9;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] din = '0;
  logic         wr = 1'b0, rd = 1'b0, rt = 1'b0, oe = 1'b1;
  logic [W-1:0] dout;
  logic         drive, full_no, empty_no, half_no, zone_no;
  int           checks = 0;
  int           errs = 0;

  always #4 clk = ~clk;

  retx_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din), .wr_i(wr), .rd_i(rd),
    .rt_i(rt), .oe_i(oe), .dout_o(dout), .drive_o(drive),
    .full_no(full_no), .empty_no(empty_no), .half_no(half_no), .zone_no(zone_no)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr = 0; rd = 0; rt = 0; oe = 1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // drive for one edge from a falling edge; outputs of that edge are sampled after
  task automatic step(input logic w, input logic r, input logic t, input logic [W-1:0] d);
    wr = w; rd = r; rt = t; din = d;
    @(negedge clk);
    wr = 0; rd = 0; rt = 0;
  endtask

  task automatic pop_exp(input string req, input int exp);
    step(0, 1, 0, '0);
    chk(req, dout, exp);
    chk(req, drive, 1);
  endtask

  task automatic chk_flags(input int k);
    chk("R7", zone_no, (k <= D/8 || k >= D - D/8) ? 0 : 1);
    chk("R8", half_no, (k > D/2) ? 0 : 1);
    chk("R12", full_no, (k == D) ? 0 : 1);
    chk("R12", empty_no, (k == 0) ? 0 : 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", full_no, 1);
    chk("R1", half_no, 1);
    chk("R1", empty_no, 0);
    chk("R1", zone_no, 0);
    chk("R1", drive, 0);
  endtask

  task automatic t_fill_wrap();
    do_reset();
    for (int k = 1; k <= D; k++) begin
      step(1, 0, 0, W'(k + 'h40));
      chk_flags(k);
    end
    step(1, 0, 0, 9'h1ff);                 // R3: blocked write
    chk("R3", full_no, 0);
    for (int k = 1; k <= D; k++) begin
      pop_exp("R2", k + 'h40);
      chk_flags(D - k);
    end
    for (int k = 1; k <= D; k++) step(1, 0, 0, W'(k + 'h80));
    chk("R12", full_no, 0);
    for (int k = 1; k <= D; k++) pop_exp("R12", k + 'h80);
    chk("R12", empty_no, 0);
    step(0, 1, 0, '0);                     // R4: blocked read
    chk("R4", drive, 0);
    step(1, 0, 0, 9'h033);
    pop_exp("R4", 'h033);
    chk("R4", empty_no, 0);
  endtask

  task automatic t_oe();
    do_reset();
    step(1, 0, 0, 9'h001);
    step(1, 0, 0, 9'h002);
    oe = 0;
    step(0, 1, 0, '0);
    chk("R9", drive, 0);
    oe = 1;
    pop_exp("R9", 'h002);
    chk("R9", empty_no, 0);
  endtask

  task automatic t_simul();
    do_reset();
    step(1, 0, 0, 9'h010);
    step(1, 0, 0, 9'h011);
    step(1, 0, 0, 9'h012);
    step(1, 1, 0, 9'h013);
    chk("R11", dout, 'h010);
    chk("R11", zone_no, 1);
    pop_exp("R11", 'h011);
    pop_exp("R11", 'h012);
    pop_exp("R11", 'h013);
    chk("R11", empty_no, 0);
  endtask

  task automatic t_rt();
    do_reset();
    for (int k = 1; k <= 5; k++) step(1, 0, 0, W'(k + 'h20));
    for (int k = 1; k <= 3; k++) pop_exp("R2", k + 'h20);
    chk("R7", zone_no, 0);
    step(0, 0, 1, '0);
    chk("R5", zone_no, 1);
    step(1, 0, 0, 9'h026);
    for (int k = 1; k <= 6; k++) pop_exp("R5", k + 'h20);
    chk("R5", empty_no, 0);
  endtask

  task automatic t_rt_ignored();
    do_reset();
    step(1, 0, 0, 9'h0a1);
    step(1, 0, 0, 9'h0a2);
    step(1, 0, 0, 9'h0a3);
    pop_exp("R2", 'h0a1);
    step(0, 1, 1, '0);
    chk("R6", dout, 'h0a2);
    step(1, 0, 1, 9'h0a4);
    pop_exp("R6", 'h0a3);
    step(0, 0, 1, '0);
    pop_exp("R5", 'h0a1);
  endtask

  task automatic t_flow();
    do_reset();
    rd = 1;
    @(negedge clk);
    chk("R10", drive, 0);
    wr = 1; din = 9'h055;
    @(negedge clk);
    wr = 0;
    chk("R10", empty_no, 1);
    @(negedge clk);
    chk("R10", dout, 'h055);
    chk("R10", drive, 1);
    wr = 1; din = 9'h066;
    @(negedge clk);
    wr = 0;
    @(negedge clk);
    chk("R10", dout, 'h055);
    rd = 0;
    @(negedge clk);
    chk("R10", drive, 0);
    pop_exp("R10", 'h066);
    chk("R10", empty_no, 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_fill_wrap();
    t_oe();
    t_simul();
    t_rt();
    t_rt_ignored();
    t_flow();
    summary();
  end
endmodule